// File: doc/BRIEF.md
# Diamond Search Winner-Select Controller

This block steers a quarter-sub-sampled diamond motion search. Each step delivers a set of nine SAD lanes, where lane k belongs to position k of the large diamond around the current search centre. The block masks the lanes that do not count in the current step and picks the lowest through a five-stage comparison tree. From the winning position it decides what to evaluate next: a small-diamond refinement, a vertex move or an edge move. When the search ends it issues a stop and gives out the motion vector.

The block keeps the accumulated centre, the direction of the last move, the best SAD so far and the number of moves taken. In a continuation step only the positions that the move newly exposes are read from the lanes. The centre slot is always filled from the retained best SAD. The memory loader receives one command pulse per step and answers with the next set of SADs.

Top module: `dsearch_ctrl`

## Requirements
- R1: After reset, cmd_valid and mv_done are 0, and mv_x, mv_y and best_sad are 0.
- R2: cmd_valid pulses for one cycle, exactly five rising edges after the edge that accepts sad_valid (counting that edge), and never earlier.
- R3: In the first step after start, all nine lanes compete. The lowest SAD wins, and on equal SADs the lower lane index wins.
- R4: cmd_kind codes are 0 = small-diamond step, 1 = vertex move, 2 = edge move, 3 = stop. cmd_idx carries the winning lane. A win at lane 4 gives 0. A win at 0, 3, 5 or 8 gives 1, and a win at 1, 2, 6 or 7 gives 2.
- R5: The lane offsets (dx,dy) are 0=(0,-2), 1=(-1,-1), 2=(1,-1), 3=(-2,0), 4=(0,0), 5=(2,0), 6=(-1,1), 7=(1,1), 8=(0,2). In a continuation step, a lane counts only if its offset plus the last move lies outside the previous large diamond. Lane 4 input is ignored and replaced by the retained best SAD.
- R6: The retained centre wins over any lane whose SAD is equal to it.
- R7: In the small-diamond step, lanes 0..3 have offsets (0,-1), (-1,0), (1,0), (0,1). Lanes 4..8 on the input are ignored. The result is a stop command together with mv_done, with best_sad set to the winning SAD.
- R8: At most 20 vertex/edge commands are issued per search. If the 21st decision would move again, the centre moves to the winner and a small-diamond step is forced.
- R9: sad_valid is ignored before the first start, while a step is still in the comparison tree, and after a stop.
- R10: The motion vector is the sum of all moves plus the final small offset, given as signed 8-bit components.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new search at centre (0,0) |
| sad_valid | input | 1 | A set of SAD lanes is present |
| sad_in | input | 9*SW | Lane k SAD in bits [k*SW +: SW] |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | Next action code (R4) |
| cmd_idx | output | 4 | Winning lane of the step |
| mv_done | output | 1 | Motion vector valid strobe |
| mv_x | output | MVW | Horizontal vector component, signed |
| mv_y | output | MVW | Vertical vector component, signed |
| best_sad | output | SW | Lowest SAD of the latest step |

## Verification
On every cycle the assertions check the command timing relative to sad_valid. They also check that the kind code agrees with the vertex and edge index classes, that mv_done coincides with a stop, the bound on moves per search and the range of the vector. Some behaviour only the bench scenarios can show: which lanes are masked after a particular move, the tie-breaking between equal SADs, the accumulation of the centre across a chain of moves, and the forced refinement after the twentieth move. These all depend on data values across several steps.

// File: rtl/dsearch_ctrl.sv
module dsearch_ctrl #(
  parameter int SW       = 16,
  parameter int MAX_ITER = 20,
  parameter int MVW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  sad_valid,
  input  logic [9*SW-1:0]       sad_in,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_kind,
  output logic [3:0]            cmd_idx,
  output logic                  mv_done,
  output logic signed [MVW-1:0] mv_x,
  output logic signed [MVW-1:0] mv_y,
  output logic [SW-1:0]         best_sad
);
  localparam int KW = SW + 5;
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [1:0] K_SMALL = 2'd0, K_VERT = 2'd1, K_EDGE = 2'd2, K_STOP = 2'd3;
  localparam logic [1:0] M_FIRST = 2'd0, M_CONT = 2'd1, M_SMALL = 2'd2;

  function automatic logic signed [2:0] ofx(input logic [3:0] k);
    case (k)
      4'd1, 4'd6: return -3'sd1;
      4'd2, 4'd7: return 3'sd1;
      4'd3:       return -3'sd2;
      4'd5:       return 3'sd2;
      default:    return 3'sd0;
    endcase
  endfunction

  function automatic logic signed [2:0] ofy(input logic [3:0] k);
    case (k)
      4'd0:       return -3'sd2;
      4'd1, 4'd2: return -3'sd1;
      4'd6, 4'd7: return 3'sd1;
      4'd8:       return 3'sd2;
      default:    return 3'sd0;
    endcase
  endfunction

  function automatic logic signed [2:0] sfx(input logic [3:0] k);
    return (k == 4'd1) ? -3'sd1 : (k == 4'd2) ? 3'sd1 : 3'sd0;
  endfunction

  function automatic logic signed [2:0] sfy(input logic [3:0] k);
    return (k == 4'd0) ? -3'sd1 : (k == 4'd3) ? 3'sd1 : 3'sd0;
  endfunction

  function automatic logic fresh(input logic [3:0] k, input logic signed [2:0] mx,
                                 input logic signed [2:0] my);
    logic signed [3:0] sx, sy;
    logic [3:0] ax, ay;
    sx = ofx(k) + mx;
    sy = ofy(k) + my;
    ax = (sx < 0) ? 4'(-sx) : 4'(sx);
    ay = (sy < 0) ? 4'(-sy) : 4'(sy);
    return (ax + ay) > 4'd2;
  endfunction

  function automatic logic [KW-1:0] pick(input logic [KW-1:0] a, input logic [KW-1:0] b);
    return (b < a) ? b : a;
  endfunction

  logic                  active, pending;
  logic [1:0]            mode;
  logic signed [MVW-1:0] cx, cy;
  logic signed [2:0]     mlx, mly;
  logic [IW-1:0]         iter;
  logic [3:0]            vpipe;
  logic [KW-1:0]         key [9];
  logic [KW-1:0]         sa [9];
  logic [KW-1:0]         sb [5];
  logic [KW-1:0]         sc [3];
  logic [KW-1:0]         sd [2];

  wire accept = sad_valid && active && !pending && !start;

  always_comb begin
    for (int k = 0; k < 9; k++) begin
      logic live;
      live = (mode == M_FIRST) || (mode == M_CONT && fresh(4'(k), mlx, mly)) ||
             (mode == M_SMALL && k < 4);
      if (k == 4 && mode != M_FIRST) key[k] = {best_sad, 1'b0, 4'd4};
      else if (live)                 key[k] = {sad_in[k*SW +: SW], 1'b1, 4'(k)};
      else                           key[k] = '1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 9; k++) sa[k] <= key[k];
    for (int k = 0; k < 4; k++) sb[k] <= pick(sa[2*k], sa[2*k+1]);
    sb[4] <= sa[8];
    sc[0] <= pick(sb[0], sb[1]);
    sc[1] <= pick(sb[2], sb[3]);
    sc[2] <= sb[4];
    sd[0] <= pick(sc[0], sc[1]);
    sd[1] <= sc[2];
  end

  wire [KW-1:0] win   = pick(sd[0], sd[1]);
  wire [3:0]    w_idx = win[3:0];
  wire [SW-1:0] w_sad = win[KW-1:5];
  wire          w_vtx = (w_idx == 4'd0) || (w_idx == 4'd3) || (w_idx == 4'd5) || (w_idx == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; pending <= 1'b0; mode <= M_FIRST; vpipe <= '0;
      cx <= '0; cy <= '0; mlx <= '0; mly <= '0; iter <= '0;
      cmd_valid <= 1'b0; cmd_kind <= K_SMALL; cmd_idx <= '0;
      mv_done <= 1'b0; mv_x <= '0; mv_y <= '0; best_sad <= '0;
    end else begin
      cmd_valid <= 1'b0;
      mv_done   <= 1'b0;
      vpipe     <= start ? 4'b0 : {vpipe[2:0], accept};
      if (start) begin
        active <= 1'b1; pending <= 1'b0; mode <= M_FIRST;
        cx <= '0; cy <= '0; mlx <= '0; mly <= '0; iter <= '0;
      end else begin
        if (accept) pending <= 1'b1;
        if (vpipe[3]) begin
          pending   <= 1'b0;
          cmd_valid <= 1'b1;
          cmd_idx   <= w_idx;
          best_sad  <= w_sad;
          if (mode == M_SMALL) begin
            cmd_kind <= K_STOP;
            mv_done  <= 1'b1;
            mv_x     <= cx + sfx(w_idx);
            mv_y     <= cy + sfy(w_idx);
            active   <= 1'b0;
          end else begin
            cx  <= cx + ofx(w_idx);
            cy  <= cy + ofy(w_idx);
            mlx <= ofx(w_idx);
            mly <= ofy(w_idx);
            if (w_idx == 4'd4 || iter == IW'(MAX_ITER)) begin
              cmd_kind <= K_SMALL;
              mode     <= M_SMALL;
            end else begin
              cmd_kind <= w_vtx ? K_VERT : K_EDGE;
              mode     <= M_CONT;
              iter     <= iter + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsearch_ctrl_chk.sv
module dsearch_ctrl_chk #(
  parameter int MAX_ITER = 20,
  parameter int MVW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  sad_valid,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_kind,
  input logic [3:0]            cmd_idx,
  input logic                  mv_done,
  input logic signed [MVW-1:0] mv_x,
  input logic signed [MVW-1:0] mv_y
);
  localparam int LIM = 2 * MAX_ITER + 3;
  int moves;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) moves <= 0;
    else if (start) moves <= 0;
    else if (cmd_valid && (cmd_kind == 2'd1 || cmd_kind == 2'd2)) moves <= moves + 1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(sad_valid, 5));

  // R4
  vertex_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1) |->
      (cmd_idx == 4'd0 || cmd_idx == 4'd3 || cmd_idx == 4'd5 || cmd_idx == 4'd8));

  // R4
  edge_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2) |->
      (cmd_idx == 4'd1 || cmd_idx == 4'd2 || cmd_idx == 4'd6 || cmd_idx == 4'd7));

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_done |-> (cmd_valid && cmd_kind == 2'd3));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd3) |-> mv_done);

  // R8
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 2'd1 || cmd_kind == 2'd2)) |-> (moves < MAX_ITER));

  // R10
  mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_done |-> (int'(mv_x) <= LIM && int'(mv_x) >= -LIM &&
                 int'(mv_y) <= LIM && int'(mv_y) >= -LIM));
endmodule

bind dsearch_ctrl dsearch_ctrl_chk #(.MAX_ITER(MAX_ITER), .MVW(MVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sad_valid(sad_valid),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_idx(cmd_idx),
  .mv_done(mv_done), .mv_x(mv_x), .mv_y(mv_y));

// File: tb/test_dsearch_ctrl.sv
module test_dsearch_ctrl;
  localparam int SW = 16;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sad_valid = 1'b0;
  logic [9*SW-1:0] sad_in = '0;
  logic cmd_valid, mv_done;
  logic [1:0] cmd_kind;
  logic [3:0] cmd_idx;
  logic signed [7:0] mv_x, mv_y;
  logic [SW-1:0] best_sad;
  int checks = 0, errors = 0;
  bit ended = 0;
  logic r_v, r_early, r_done;
  logic [1:0] r_kind;
  logic [3:0] r_idx;
  logic signed [7:0] r_mx, r_my;
  logic [SW-1:0] r_best;

  always #5 clk = ~clk;

  dsearch_ctrl i_dsearch_ctrl (.clk(clk), .rst_n(rst_n), .start(start), .sad_valid(sad_valid),
    .sad_in(sad_in), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_idx(cmd_idx),
    .mv_done(mv_done), .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad));

  // first-step vectors: [75:72] expected winner, lane k SAD in [8k+7:8k]
  localparam logic [75:0] TAB [9] = '{
    {4'd4, 72'h50_50_50_50_10_50_50_50_50},
    {4'd0, 72'h50_50_50_50_50_50_50_50_05},
    {4'd7, 72'h50_01_50_50_50_50_50_50_50},
    {4'd2, 72'h50_50_03_50_50_50_03_50_50},
    {4'd3, 72'h50_50_50_50_20_20_50_50_50},
    {4'd8, 72'h00_50_50_50_50_50_50_50_50},
    {4'd5, 72'h0F_50_50_0F_50_50_50_50_50},
    {4'd1, 72'h50_50_50_50_50_50_50_02_50},
    {4'd6, 72'hFF_FF_FE_FF_FF_FF_FF_FF_FF}
  };

  function automatic logic [9*SW-1:0] pk(input logic [71:0] b);
    logic [9*SW-1:0] v;
    for (int k = 0; k < 9; k++) v[k*SW +: SW] = SW'(b[8*k +: 8]);
    return v;
  endfunction

  function automatic logic [1:0] cls(input logic [3:0] i);
    if (i == 4'd4) return 2'd0;
    if (i == 4'd0 || i == 4'd3 || i == 4'd5 || i == 4'd8) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [71:0] one5(input logic [7:0] v);
    logic [71:0] b;
    b = '1;
    b[40 +: 8] = v;
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic step(input logic [71:0] b);
    @(negedge clk);
    sad_valid = 1'b1;
    sad_in = pk(b);
    @(negedge clk) sad_valid = 1'b0;
    repeat (3) @(negedge clk);
    r_early = cmd_valid;
    @(negedge clk);
    r_v = cmd_valid; r_kind = cmd_kind; r_idx = cmd_idx; r_done = mv_done;
    r_mx = mv_x; r_my = mv_y; r_best = best_sad;
  endtask

  task automatic quiet(input string tag);
    int seen;
    seen = 0;
    @(negedge clk);
    sad_valid = 1'b1;
    sad_in = '0;
    @(negedge clk) sad_valid = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (cmd_valid) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!cmd_valid && !mv_done, "R1 strobes", {cmd_valid, mv_done}, 0);
    chk(mv_x == 0 && mv_y == 0 && best_sad == 0, "R1 values", int'(best_sad), 0);

    // R9 before any start
    quiet("R9 idle");

    // R3 R4 R2 table
    for (int n = 0; n < 9; n++) begin
      go();
      step(TAB[n][71:0]);
      chk(!r_early && r_v, "R2 timing", {r_early, r_v}, 1);
      chk(r_idx == TAB[n][75:72], "R3 winner", r_idx, TAB[n][75:72]);
      chk(r_kind == cls(TAB[n][75:72]), "R4 kind", r_kind, cls(TAB[n][75:72]));
    end

    // R7 centre first then refinement
    go();
    step(72'hC8_C8_C8_C8_64_C8_C8_C8_C8);
    chk(r_kind == 2'd0 && r_idx == 4'd4, "R4 centre", r_idx, 4);
    step(72'h00_00_00_00_00_5F_55_50_5A);
    chk(r_kind == 2'd3 && r_done, "R7 stop", r_kind, 3);
    chk(r_mx == -1 && r_my == 0, "R7 mv", int'(r_mx), -1);
    chk(r_best == 80, "R7 best", int'(r_best), 80);
    // R9 after stop
    quiet("R9 after stop");

    // R5 R6 R10 chain of moves
    go();
    step(72'h90_90_90_32_90_90_90_90_90);
    chk(r_kind == 2'd1 && r_idx == 4'd5, "R4 vertex", r_idx, 5);
    step(72'h90_1E_90_90_01_01_90_90_90);
    chk(r_kind == 2'd2 && r_idx == 4'd7, "R5 masked lanes", r_idx, 7);
    step(72'h1E_28_00_28_00_00_00_00_00);
    chk(r_kind == 2'd0 && r_idx == 4'd4, "R6 retained tie", r_idx, 4);
    chk(r_best == 30, "R6 best", int'(r_best), 30);
    step(72'h00_00_00_00_00_1E_1E_1E_1E);
    chk(r_done && r_idx == 4'd4, "R7 centre tie", r_idx, 4);
    chk(r_mx == 3 && r_my == 1, "R10 mv", int'(r_mx) * 100 + int'(r_my), 301);

    // R9 while a step is in flight
    go();
    @(negedge clk);
    sad_valid = 1'b1;
    sad_in = pk(72'h50_50_50_50_50_50_50_50_05);
    @(negedge clk) sad_in = '0;
    @(negedge clk) sad_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid && cmd_idx == 4'd0, "R9 busy first", cmd_idx, 0);
    begin
      int extra;
      extra = 0;
      repeat (8) begin
        @(negedge clk);
        if (cmd_valid) extra++;
      end
      chk(extra == 0, "R9 busy extra", extra, 0);
    end

    // R8 iteration cap
    go();
    begin
      int vcount;
      vcount = 0;
      for (int i = 0; i < 20; i++) begin
        step(one5(8'(200 - i)));
        if (r_v && r_kind == 2'd1 && r_idx == 4'd5) vcount++;
      end
      chk(vcount == 20, "R8 vertex count", vcount, 20);
    end
    step(one5(8'd180));
    chk(r_v && r_kind == 2'd0 && r_idx == 4'd5, "R8 forced small", r_kind, 0);
    step('1);
    chk(r_done && r_idx == 4'd4, "R8 stop", r_idx, 4);
    chk(r_mx == 42 && r_my == 0, "R10 capped mv", int'(r_mx), 42);
    chk(r_best == 180, "R7 capped best", int'(r_best), 180);

    finish_run();
  end
endmodule